// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block stands between a simple processor core and 26 numbered interrupt slots. Slot 1 is a non-maskable reset request. Slots 2 to 26 are maskable sources. Each maskable source has a pending flag, which a one-cycle trigger pulse sets, and an enable bit of its own. A global enable flag gates every maskable request. The highest-priority eligible slot, which is the one with the lowest number, is offered to the core as a program-memory word address and a slot index.

The core accepts the offer with a one-cycle take strobe. On that strobe the block clears the winner's pending flag, clears the global enable and returns a one-hot acknowledge on the next cycle. It then moves from state ST_IDLE to state ST_SERVICE. In ST_SERVICE no maskable slot is offered, so service routines never nest. A return strobe moves the controller back to ST_IDLE and sets the global enable again. The next pending slot is then offered in ascending order. A source that fires several times while masked is serviced once. The reset request bypasses every mask and can be offered in either state.

The controller has two states. ST_IDLE goes to ST_SERVICE on an accepted take. ST_SERVICE stays in ST_SERVICE on an accepted take, which can only be the reset slot. ST_SERVICE goes back to ST_IDLE on a return strobe when no take is accepted in the same cycle.

Top module: `irq_vec_ctrl`

## Requirements
- R1: When `rst` is high at a clock edge, all pending flags, all source enables and the global enable are cleared, and the state becomes ST_IDLE. After reset, `irq_valid`, `irq_vector`, `irq_index` and `irq_ack` are all zero.
- R2: Slot s is mapped as follows:
  - Slot 1 is `rst_req`. Slot s ≥ 2 is `src_trig[s-2]`, and its enable is `en_wdata[s-2]`.
  - While slot s is offered, `irq_index` is s−1 and `irq_vector` is the word address 2·(s−1). For example, slot 4 gives 0x0006 and slot 26 gives 0x0032.
- R3: A trigger pulse sets the slot's pending flag. The flag stays set, across any number of cycles and any enable changes, until that slot is acknowledged or `rst` is applied.
- R4: A maskable slot is offered only when all of these hold:
  - its pending flag is set;
  - its own enable bit is set;
  - the global enable is set;
  - the state is ST_IDLE.
- R5: Among eligible slots, the lowest slot number is offered. After each return, the next lowest pending slot is offered, until none remain.
- R6: A take strobe while `irq_valid` is high has these effects:
  - On the next cycle, `irq_ack` has exactly one bit set, bit s−1 for the winning slot s, for one cycle.
  - The winner's pending flag and the global enable are cleared.
  - The state becomes ST_SERVICE.
  
  A take strobe while `irq_valid` is low has no effect.
- R7: In ST_SERVICE, no maskable slot is offered, even if `gie_set` is pulsed. A `reti` strobe returns the state to ST_IDLE and sets the global enable.
- R8: A source triggered several times while masked is serviced only once.
- R9: A trigger that arrives in the same cycle as that slot's accepted take leaves the slot pending.
- R10: A `rst_req` pulse makes the next cycle show `irq_valid`=1, `irq_vector`=0x0000 and `irq_index`=0. This holds whatever the enables or the state.
- R11: `gie_set` sets the global enable and `gie_clr` clears it. Within one cycle, an accepted take wins over `gie_clr`, and `gie_clr` wins over `gie_set` and `reti`.
- R12: While nothing is offered, `irq_vector` and `irq_index` are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous block reset, active high |
| rst_req | input | 1 | Non-maskable reset request (slot 1), one-cycle pulse |
| src_trig | input | NSLOT-1 | Trigger pulses; bit i is slot i+2 |
| en_we | input | 1 | Write strobe for the source enables |
| en_wdata | input | NSLOT-1 | New source enables; bit i is slot i+2 |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_take | input | 1 | Core accepts the offered request |
| irq_valid | output | 1 | A request is offered |
| irq_vector | output | VEC_W | Vector word address of the offered slot |
| irq_index | output | IDX_W | Offered slot number minus one |
| irq_ack | output | NSLOT | One-hot acknowledge; bit s−1 for slot s |

## Verification
The assertions check the following on every cycle:
- the zero vector and index while idle;
- the vector-to-index mapping;
- acknowledges that are one-hot and appear only after an accepted take;
- that only the reset slot can follow a take;
- that the reset request forces vector zero.

The bench scenarios show the rest:
- the ascending service order over several returns;
- the collapse of repeated triggers into one service;
- a trigger that coincides with its own acknowledge;
- the cycle-level priority among the global-enable commands;
- persistence of pending flags across enable changes.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_SERVICE = 1'b1
    } svc_state_e;
endpackage

// File: rtl/irq_pend_bank.sv
// One pending flag per slot: set by a trigger pulse, cleared on acknowledge.
// A trigger arriving in the clear cycle keeps the flag set.
module irq_pend_bank #(
    parameter int N = 26
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                pend[g] <= 1'b0;
            else if (trig[g])
                pend[g] <= 1'b1;
            else if (clr[g])
                pend[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Fixed priority: the lowest set bit wins.
module irq_prio_enc #(
    parameter int N  = 26,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_pkg::*;
#(
    parameter int NSLOT = 26,
    parameter int VEC_W = 16,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_req,
    input  logic [NSLOT-2:0] src_trig,
    input  logic             en_we,
    input  logic [NSLOT-2:0] en_wdata,
    input  logic             gie_set,
    input  logic             gie_clr,
    input  logic             reti,
    input  logic             irq_take,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector,
    output logic [IDX_W-1:0] irq_index,
    output logic [NSLOT-1:0] irq_ack
);
    localparam int NSRC = NSLOT - 1;

    svc_state_e       state_q, state_d;
    logic [NSRC-1:0]  en_q;
    logic             gie_q;
    logic [NSLOT-1:0] pend, trig_all, clr_all, elig;
    logic             any;
    logic [IDX_W-1:0] win;
    logic             mask_ok, taking;

    assign trig_all = {src_trig, rst_req};
    assign mask_ok  = gie_q && (state_q == ST_IDLE);
    assign elig     = pend & {({NSRC{mask_ok}} & en_q), 1'b1};
    assign taking   = irq_take && any;
    assign clr_all  = taking ? (NSLOT'(1) << win) : '0;

    irq_pend_bank #(.N(NSLOT)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .trig (trig_all),
        .clr  (clr_all),
        .pend (pend)
    );

    irq_prio_enc #(.N(NSLOT), .IW(IDX_W)) u_enc (
        .req (elig),
        .any (any),
        .idx (win)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (taking) state_d = ST_SERVICE;
            ST_SERVICE: if (taking) state_d = ST_SERVICE;
                        else if (reti) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State, enables, global flag and acknowledge registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            en_q    <= '0;
            gie_q   <= 1'b0;
            irq_ack <= '0;
        end else begin
            state_q <= state_d;
            irq_ack <= clr_all;
            if (en_we)
                en_q <= en_wdata;
            if (taking || gie_clr)
                gie_q <= 1'b0;
            else if (gie_set || reti)
                gie_q <= 1'b1;
        end
    end

    // Offer outputs
    always_comb begin
        irq_valid  = any;
        irq_index  = any ? win : '0;
        irq_vector = any ? (VEC_W'(win) << 1) : '0;
    end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
    parameter int NSLOT = 26,
    parameter int VEC_W = 16,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             rst_req,
    input logic             irq_take,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vector,
    input logic [IDX_W-1:0] irq_index,
    input logic [NSLOT-1:0] irq_ack
);
    a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !irq_valid |-> (irq_vector == '0 && irq_index == '0));

    a_r2_vector_map: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_vector == (VEC_W'(irq_index) << 1)));

    a_r6_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_ack));

    a_r6_ack_after_take: assert property (@(posedge clk) disable iff (rst)
        (irq_take && irq_valid) |=> ($countones(irq_ack) == 1));

    a_r6_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
        !(irq_take && irq_valid) |=> (irq_ack == '0));

    a_r7_no_nest: assert property (@(posedge clk) disable iff (rst)
        (irq_take && irq_valid) |=> (!irq_valid || irq_index == '0));

    a_r10_reset_vector: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> (irq_valid && irq_vector == '0));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
    .NSLOT (NSLOT),
    .VEC_W (VEC_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rst_req    (rst_req),
    .irq_take   (irq_take),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector),
    .irq_index  (irq_index),
    .irq_ack    (irq_ack)
);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
    localparam int NSLOT = 26;
    localparam int VEC_W = 16;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rst_req = 1'b0;
    logic [NSLOT-2:0] src_trig = '0;
    logic             en_we = 1'b0;
    logic [NSLOT-2:0] en_wdata = '0;
    logic             gie_set = 1'b0, gie_clr = 1'b0, reti = 1'b0, irq_take = 1'b0;
    logic             irq_valid;
    logic [VEC_W-1:0] irq_vector;
    logic [IDX_W-1:0] irq_index;
    logic [NSLOT-1:0] irq_ack;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;
    int cyc_cnt = 0;

    always #10 clk = ~clk;

    irq_vec_ctrl #(.NSLOT(NSLOT), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst), .rst_req(rst_req), .src_trig(src_trig),
        .en_we(en_we), .en_wdata(en_wdata), .gie_set(gie_set), .gie_clr(gie_clr),
        .reti(reti), .irq_take(irq_take), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_index(irq_index), .irq_ack(irq_ack)
    );

    // Behavioural reference model
    bit [NSLOT-1:0] m_pend, m_en, m_ack;
    bit             m_gie, m_busy;

    function automatic int pick(bit [NSLOT-1:0] p, bit [NSLOT-1:0] e, bit g, bit b);
        for (int k = 0; k < NSLOT; k++)
            if (p[k] && (k == 0 || (e[k] && g && !b))) return k;
        return -1;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int w;
        started = 1;
        if (rst) begin
            m_pend = '0; m_en = '0; m_gie = 0; m_busy = 0; m_ack = '0;
        end else begin
            w = pick(m_pend, m_en, m_gie, m_busy);
            m_ack = '0;
            if (irq_take && w >= 0) begin
                m_ack[w] = 1'b1;
                m_pend[w] = 1'b0;
                m_busy = 1;
                m_gie = 0;
            end else begin
                if (gie_clr) m_gie = 0;
                else if (gie_set || reti) m_gie = 1;
                if (reti) m_busy = 0;
            end
            if (rst_req) m_pend[0] = 1'b1;
            for (int k = 1; k < NSLOT; k++) begin
                if (src_trig[k-1]) m_pend[k] = 1'b1;
                if (en_we) m_en[k] = en_wdata[k-1];
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        int w;
        if (started && !done) begin
            w = pick(m_pend, m_en, m_gie, m_busy);
            check("R4 valid", int'(irq_valid), int'(w >= 0));
            check("R2 index", int'(irq_index), (w >= 0) ? w : 0);
            check("R2 vector", int'(irq_vector), (w >= 0) ? 2 * w : 0);
            check("R6 ack", int'(irq_ack), int'(m_ack));
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        rst_req = 0; src_trig = '0; en_we = 0; gie_set = 0; gie_clr = 0;
        reti = 0; irq_take = 0; rst = 0;
    endtask

    task automatic trig(int slot);
        src_trig[slot-2] = 1'b1; tick(); idle_inputs();
    endtask

    task automatic take(); irq_take = 1; tick(); idle_inputs(); endtask
    task automatic ret();  reti = 1;     tick(); idle_inputs(); endtask
    task automatic sei();  gie_set = 1;  tick(); idle_inputs(); endtask
    task automatic set_en(logic [NSLOT-2:0] v);
        en_we = 1; en_wdata = v; tick(); idle_inputs();
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 5000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=<5000", cyc_cnt);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        rst = 1; tick(); tick(); tick();
        idle_inputs(); tick();
        // R1 reset state
        check("R1 valid", int'(irq_valid), 0);
        check("R1 vector", int'(irq_vector), 0);
        check("R1 ack", int'(irq_ack), 0);

        set_en('1);
        trig(20); trig(20); trig(20); trig(4);
        check("R4 masked by global enable", int'(irq_valid), 0);
        sei();
        check("R5 lowest slot", int'(irq_index), 3);
        check("R2 slot 4 vector", int'(irq_vector), 16'h0006);
        take();
        check("R6 ack bit", int'(irq_ack), 1 << 3);
        check("R7 no nesting", int'(irq_valid), 0);
        tick();
        check("R6 ack one cycle", int'(irq_ack), 0);
        sei();
        check("R7 set in service", int'(irq_valid), 0);
        ret();
        check("R7 return offers next", int'(irq_valid), 1);
        check("R5 next slot", int'(irq_index), 19);
        check("R2 slot 20 vector", int'(irq_vector), 16'h0026);
        take();
        check("R6 ack slot 20", int'(irq_ack), 1 << 19);
        ret();
        check("R8 serviced once", int'(irq_valid), 0);

        // R9 trigger in the acknowledge cycle
        trig(9);
        check("R9 offered", int'(irq_index), 8);
        irq_take = 1; src_trig[7] = 1; tick(); idle_inputs();
        check("R9 ack", int'(irq_ack), 1 << 8);
        ret();
        check("R9 still pending", int'(irq_valid), 1);
        check("R9 index", int'(irq_index), 8);
        take(); ret();
        check("R9 drained", int'(irq_valid), 0);

        // R6 take with nothing offered
        take();
        check("R6 ignored take ack", int'(irq_ack), 0);
        check("R6 ignored take valid", int'(irq_valid), 0);

        // R10 reset request bypasses masks
        gie_clr = 1; tick(); idle_inputs();
        set_en('0);
        rst_req = 1; tick(); idle_inputs();
        check("R10 valid", int'(irq_valid), 1);
        check("R10 vector", int'(irq_vector), 0);
        take();
        check("R10 ack", int'(irq_ack), 1);
        ret();

        // R11 clear wins over set
        set_en('1);
        trig(2);
        check("R2 slot 2 vector", int'(irq_vector), 16'h0002);
        gie_set = 1; gie_clr = 1; tick(); idle_inputs();
        check("R11 clear wins", int'(irq_valid), 0);
        sei();
        check("R11 set", int'(irq_valid), 1);
        take(); ret();

        // R2 last slot
        trig(26);
        check("R2 slot 26 vector", int'(irq_vector), 16'h0032);
        take(); ret();

        // R5 ascending order
        src_trig[24] = 1; src_trig[5] = 1; src_trig[1] = 1; tick(); idle_inputs();
        check("R5 first", int'(irq_index), 2);
        take(); ret();
        check("R5 second", int'(irq_index), 6);
        take(); ret();
        check("R5 third", int'(irq_index), 25);
        take(); ret();
        check("R5 empty", int'(irq_valid), 0);

        // R1 reset mid-operation
        trig(5);
        rst = 1; tick(); idle_inputs();
        sei();
        check("R1 pending and enables cleared", int'(irq_valid), 0);

        // R3 pending persists
        trig(12);
        tick(); tick(); tick(); tick();
        set_en('1);
        check("R3 pending kept", int'(irq_index), 11);
        check("R3 valid", int'(irq_valid), 1);
        take(); ret();
        tick();
        finish_run();
    end
endmodule